// File: doc/BRIEF.md
# Camera frame capture sequencer

This block sits between a parallel image sensor and a DMA engine. It watches the sensor's pixel clock, line sync and frame sync as ordinary inputs in the system clock domain. It picks out the sampling instants on the selected pixel clock edge and applies the selected sync polarities. It then tracks lines and pixels against a programmed frame width and height. Every accepted pixel is handed to the DMA side together with the index of the frame buffer it belongs to.

Frame buffers are used in a ring of three, or a ring of two when that mode is selected. Each buffer index has its own start-of-frame and end-of-frame event. A FIFO-full indication from the DMA side raises an overflow event and drops the rest of the frame. All events collect in a sticky raw status vector. A mask vector with the same layout selects which events drive the interrupt line. Software clears events by writing ones, and a new event in the same cycle wins over the clear.

Top module: `cam_frame_seq`

## Requirements
- R1: After reset, raw_status is 0, masked_status is 0, irq is 0, pix_valid is 0 and buf_idx is 0.
- R2: While cfg_enable is 0 no frame is started, pix_valid stays 0, no status bit is set and buf_idx returns to 0.
- R3: With cfg_enable set, a frame starts at an active edge of the frame sync seen at a pixel sampling instant, and the start-of-frame bit for the current buffer is set (bit 3 + buf_idx).
- R4: Within a running frame, a pixel is presented with pix_valid, its data and buf_idx one system cycle after a sampling instant at which line sync is active, and only for the first cfg_hsize pixels of each line; extra pixels in a line are ignored.
- R5: When the line sync goes inactive for the cfg_vsize-th time in a running frame, the end-of-frame bit for the current buffer is set (bit buf_idx) and buf_idx advances.
- R6: buf_idx steps 0,1,2,0 in three-buffer mode and 0,1,0 when cfg_two_buf is 1.
- R7: A frame sync edge that arrives before cfg_vsize lines have ended aborts the frame: no end-of-frame bit, buf_idx unchanged, and a new frame starts with its start-of-frame bit for the same buffer.
- R8: fifo_full high at a sampling instant with a presented pixel sets bit 6; later pixels of that frame are not presented, its end-of-frame bit is not set and buf_idx is not advanced.
- R9: masked_status equals raw_status AND the mask written through mask_wr, and irq is 1 exactly when masked_status is nonzero.
- R10: A stat_clr write clears each raw_status bit whose stat_clr_data bit is 1; an event in the same cycle as the clear of its bit leaves the bit set.
- R11: cfg_hsync_low and cfg_vsync_low make the corresponding syncs active low, and cfg_pclk_fall moves the sampling instant to the falling edge of the pixel clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Master capture enable |
| cfg_hsync_low | input | 1 | Line sync active low |
| cfg_vsync_low | input | 1 | Frame sync active low |
| cfg_pclk_fall | input | 1 | Sample on falling pixel clock edge |
| cfg_two_buf | input | 1 | Rotate through two buffers only |
| cfg_hsize | input | H_W (14) | Pixels per line |
| cfg_vsize | input | V_W (13) | Lines per frame |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | NIRQ (7) | New interrupt mask |
| stat_clr | input | 1 | Write-one-to-clear strobe |
| stat_clr_data | input | NIRQ (7) | Bits to clear |
| raw_status | output | NIRQ (7) | Sticky events: end of frame per buffer [2:0], start of frame per buffer [5:3], overflow [6] |
| masked_status | output | NIRQ (7) | raw_status AND mask |
| irq | output | 1 | Interrupt request |
| sen_pclk | input | 1 | Sensor pixel clock, oversampled |
| sen_hsync | input | 1 | Sensor line sync |
| sen_vsync | input | 1 | Sensor frame sync |
| sen_data | input | DATA_W (8) | Sensor pixel data |
| fifo_full | input | 1 | DMA FIFO cannot take a pixel |
| pix_valid | output | 1 | Pixel presented to DMA |
| pix_data | output | DATA_W (8) | Presented pixel |
| buf_idx | output | BUF_W (2) | Buffer the current frame goes to |

## Verification
Frames are driven with lines longer than the programmed width, so the scoreboard distinguishes a correct width cut-off from a passthrough of every pixel. Runs of complete frames in both ring sizes separate correct wrap points, while an early frame sync and a mid-frame FIFO-full each show that a frame is abandoned without an end event or buffer advance. A clear issued in the very cycle of a start event tells set-wins from clear-wins, and a final frame with inverted syncs and falling-edge sampling shows that polarity and edge selection act on the same path.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RUN  = 2'd1,
        FR_DROP = 2'd2
    } frame_st_e;

    // Sensor qualifiers produced at a sampling instant
    typedef struct packed {
        logic strobe;   // sampling instant on the selected pixel clock edge
        logic hs_act;   // line sync active (polarity applied)
        logic hs_fall;  // line sync left the active state at this instant
        logic vs_rise;  // frame sync entered the active state at this instant
    } sens_evt_t;

endpackage

// File: rtl/cfs_sensor_front.sv
module cfs_sensor_front
    import cfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_hsync_low,
    input  logic      cfg_vsync_low,
    input  logic      cfg_pclk_fall,
    input  logic      sen_pclk,
    input  logic      sen_hsync,
    input  logic      sen_vsync,
    output sens_evt_t evt
);

    typedef struct packed {
        logic pclk;
        logic hs;
        logic vs;
    } front_t;

    front_t fr_d, fr_q;
    logic   hs_now, vs_now, strobe;

    always_comb begin
        hs_now = sen_hsync ^ cfg_hsync_low;
        vs_now = sen_vsync ^ cfg_vsync_low;
        strobe = cfg_pclk_fall ? (fr_q.pclk & ~sen_pclk) : (~fr_q.pclk & sen_pclk);

        fr_d      = fr_q;
        fr_d.pclk = sen_pclk;
        if (strobe) begin
            fr_d.hs = hs_now;
            fr_d.vs = vs_now;
        end

        evt.strobe  = strobe;
        evt.hs_act  = hs_now;
        evt.hs_fall = strobe & fr_q.hs & ~hs_now;
        evt.vs_rise = strobe & ~fr_q.vs & vs_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

endmodule

// File: rtl/cfs_frame_track.sv
module cfs_frame_track
    import cfs_pkg::*;
#(
    parameter int NUM_BUF = 3,
    parameter int H_W     = 14,
    parameter int V_W     = 13,
    parameter int DATA_W  = 8,
    parameter int BUF_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sens_evt_t          evt,
    input  logic [DATA_W-1:0]  sen_data,
    input  logic               fifo_full,
    input  logic               cfg_enable,
    input  logic               cfg_two_buf,
    input  logic [H_W-1:0]     cfg_hsize,
    input  logic [V_W-1:0]     cfg_vsize,
    output logic               pix_valid,
    output logic [DATA_W-1:0]  pix_data,
    output logic [BUF_W-1:0]   buf_idx,
    output logic [NUM_BUF-1:0] sof_ev,
    output logic [NUM_BUF-1:0] eof_ev,
    output logic               ovf_ev
);

    typedef struct packed {
        frame_st_e         st;
        logic [H_W-1:0]    hcnt;
        logic [V_W-1:0]    vcnt;
        logic [BUF_W-1:0]  bidx;
        logic              pv;
        logic [DATA_W-1:0] pd;
    } trk_t;

    trk_t             trk_d, trk_q;
    logic [BUF_W-1:0] last_idx;
    logic [V_W:0]     lines_after;
    logic             pix_ok, frame_done;

    always_comb begin
        last_idx    = cfg_two_buf ? BUF_W'(1) : BUF_W'(NUM_BUF - 1);
        lines_after = {1'b0, trk_q.vcnt} + 1'b1;

        trk_d      = trk_q;
        trk_d.pv   = 1'b0;
        sof_ev     = '0;
        eof_ev     = '0;
        ovf_ev     = 1'b0;
        pix_ok     = 1'b0;
        frame_done = 1'b0;

        if (!cfg_enable) begin
            trk_d.st   = FR_IDLE;
            trk_d.bidx = '0;
            trk_d.hcnt = '0;
            trk_d.vcnt = '0;
        end else if (evt.vs_rise) begin
            // start of a new frame, or restart after an early frame sync
            trk_d.st   = FR_RUN;
            trk_d.hcnt = '0;
            trk_d.vcnt = '0;
            for (int i = 0; i < NUM_BUF; i++) begin
                if (trk_q.bidx == BUF_W'(i)) sof_ev[i] = 1'b1;
            end
        end else if ((trk_q.st != FR_IDLE) && evt.strobe) begin
            pix_ok = evt.hs_act && (trk_q.hcnt < cfg_hsize);
            if (pix_ok) begin
                trk_d.hcnt = trk_q.hcnt + 1'b1;
                if (trk_q.st == FR_RUN) begin
                    trk_d.pv = 1'b1;
                    trk_d.pd = sen_data;
                    if (fifo_full) begin
                        ovf_ev   = 1'b1;
                        trk_d.st = FR_DROP;
                    end
                end
            end
            if (evt.hs_fall) begin
                trk_d.hcnt = '0;
                trk_d.vcnt = trk_q.vcnt + 1'b1;
                frame_done = (lines_after == {1'b0, cfg_vsize});
                if (frame_done) begin
                    trk_d.st = FR_IDLE;
                    if (trk_q.st == FR_RUN) begin
                        for (int i = 0; i < NUM_BUF; i++) begin
                            if (trk_q.bidx == BUF_W'(i)) eof_ev[i] = 1'b1;
                        end
                        trk_d.bidx = (trk_q.bidx >= last_idx) ? '0 : trk_q.bidx + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pix_valid = trk_q.pv;
    assign pix_data  = trk_q.pd;
    assign buf_idx   = trk_q.bidx;

endmodule

// File: rtl/cfs_irq_regs.sv
module cfs_irq_regs #(
    parameter int NIRQ = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] ev,
    input  logic            mask_wr,
    input  logic [NIRQ-1:0] mask_wdata,
    input  logic            stat_clr,
    input  logic [NIRQ-1:0] stat_clr_data,
    output logic [NIRQ-1:0] raw_status,
    output logic [NIRQ-1:0] masked_status,
    output logic            irq
);

    typedef struct packed {
        logic [NIRQ-1:0] raw;
        logic [NIRQ-1:0] mask;
    } irq_t;

    irq_t            irq_d, irq_q;
    logic [NIRQ-1:0] clr_bits;

    always_comb begin
        clr_bits  = stat_clr ? stat_clr_data : '0;
        irq_d     = irq_q;
        // a fresh event overrides a clear of the same bit
        irq_d.raw = (irq_q.raw & ~clr_bits) | ev;
        if (mask_wr) irq_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign raw_status    = irq_q.raw;
    assign masked_status = irq_q.raw & irq_q.mask;
    assign irq           = |masked_status;

endmodule

// File: rtl/cam_frame_seq.sv
module cam_frame_seq
    import cfs_pkg::*;
#(
    parameter int NUM_BUF = 3,
    parameter int H_W     = 14,
    parameter int V_W     = 13,
    parameter int DATA_W  = 8,
    localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int NIRQ   = 2 * NUM_BUF + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_hsync_low,
    input  logic              cfg_vsync_low,
    input  logic              cfg_pclk_fall,
    input  logic              cfg_two_buf,
    input  logic [H_W-1:0]    cfg_hsize,
    input  logic [V_W-1:0]    cfg_vsize,
    input  logic              mask_wr,
    input  logic [NIRQ-1:0]   mask_wdata,
    input  logic              stat_clr,
    input  logic [NIRQ-1:0]   stat_clr_data,
    output logic [NIRQ-1:0]   raw_status,
    output logic [NIRQ-1:0]   masked_status,
    output logic              irq,
    input  logic              sen_pclk,
    input  logic              sen_hsync,
    input  logic              sen_vsync,
    input  logic [DATA_W-1:0] sen_data,
    input  logic              fifo_full,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic [BUF_W-1:0]  buf_idx
);

    sens_evt_t          evt;
    logic [NUM_BUF-1:0] sof_ev, eof_ev;
    logic               ovf_ev;
    logic [NIRQ-1:0]    ev_vec;

    cfs_sensor_front u_front (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_hsync_low (cfg_hsync_low),
        .cfg_vsync_low (cfg_vsync_low),
        .cfg_pclk_fall (cfg_pclk_fall),
        .sen_pclk      (sen_pclk),
        .sen_hsync     (sen_hsync),
        .sen_vsync     (sen_vsync),
        .evt           (evt)
    );

    cfs_frame_track #(
        .NUM_BUF (NUM_BUF),
        .H_W     (H_W),
        .V_W     (V_W),
        .DATA_W  (DATA_W),
        .BUF_W   (BUF_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .sen_data    (sen_data),
        .fifo_full   (fifo_full),
        .cfg_enable  (cfg_enable),
        .cfg_two_buf (cfg_two_buf),
        .cfg_hsize   (cfg_hsize),
        .cfg_vsize   (cfg_vsize),
        .pix_valid   (pix_valid),
        .pix_data    (pix_data),
        .buf_idx     (buf_idx),
        .sof_ev      (sof_ev),
        .eof_ev      (eof_ev),
        .ovf_ev      (ovf_ev)
    );

    // status layout: end-of-frame per buffer, then start-of-frame per buffer, then overflow
    assign ev_vec = {ovf_ev, sof_ev, eof_ev};

    cfs_irq_regs #(
        .NIRQ (NIRQ)
    ) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev            (ev_vec),
        .mask_wr       (mask_wr),
        .mask_wdata    (mask_wdata),
        .stat_clr      (stat_clr),
        .stat_clr_data (stat_clr_data),
        .raw_status    (raw_status),
        .masked_status (masked_status),
        .irq           (irq)
    );

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
    parameter int NUM_BUF = 3,
    localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int NIRQ   = 2 * NUM_BUF + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             pix_valid,
    input logic [BUF_W-1:0] buf_idx,
    input logic [NIRQ-1:0]  raw_status,
    input logic [NIRQ-1:0]  masked_status,
    input logic             irq,
    input logic             stat_clr,
    input logic [NIRQ-1:0]  stat_clr_data
);

    AST_NO_PIX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !pix_valid); // R2

    AST_BUF_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        buf_idx < BUF_W'(NUM_BUF)); // R6

    AST_BUF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_idx) |-> (buf_idx == '0 || buf_idx == $past(buf_idx) + 1'b1)); // R6

    AST_EOF0_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_status[0]) |-> ($past(buf_idx) == '0 && buf_idx == BUF_W'(1))); // R5

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(raw_status) & ~($past(stat_clr) ? $past(stat_clr_data) : '0)) & ~raw_status) == '0); // R10

    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status & ~raw_status) == '0); // R9

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (masked_status != '0)); // R9

endmodule

bind cam_frame_seq cfs_checker #(.NUM_BUF(NUM_BUF)) u_cfs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_enable    (cfg_enable),
    .pix_valid     (pix_valid),
    .buf_idx       (buf_idx),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq           (irq),
    .stat_clr      (stat_clr),
    .stat_clr_data (stat_clr_data)
);

// File: tb/test_cam_frame_seq.sv
module test_cam_frame_seq;

    localparam int HS = 4;
    localparam int VS = 3;
    localparam int NPX = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_hsync_low = 1'b0, cfg_vsync_low = 1'b0;
    logic        cfg_pclk_fall = 1'b0, cfg_two_buf = 1'b0;
    logic [13:0] cfg_hsize = 14'(HS);
    logic [12:0] cfg_vsize = 13'(VS);
    logic        mask_wr = 1'b0, stat_clr = 1'b0;
    logic [6:0]  mask_wdata = '0, stat_clr_data = '0;
    logic [6:0]  raw_status, masked_status;
    logic        irq;
    logic        sen_pclk = 1'b0, sen_hsync = 1'b0, sen_vsync = 1'b0;
    logic [7:0]  sen_data = '0;
    logic        fifo_full = 1'b0;
    logic        pix_valid;
    logic [7:0]  pix_data;
    logic [1:0]  buf_idx;

    int checks = 0;
    int errors = 0;
    logic [1:0]  exp_buf = '0;
    logic        dropped = 1'b0;
    logic        pend_en = 1'b0;
    logic [6:0]  pend_clr = '0;
    logic [9:0]  sb_q[$];

    cam_frame_seq i_cam_frame_seq (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_hsync_low(cfg_hsync_low), .cfg_vsync_low(cfg_vsync_low),
        .cfg_pclk_fall(cfg_pclk_fall), .cfg_two_buf(cfg_two_buf),
        .cfg_hsize(cfg_hsize), .cfg_vsize(cfg_vsize),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .stat_clr(stat_clr), .stat_clr_data(stat_clr_data),
        .raw_status(raw_status), .masked_status(masked_status), .irq(irq),
        .sen_pclk(sen_pclk), .sen_hsync(sen_hsync), .sen_vsync(sen_vsync),
        .sen_data(sen_data), .fifo_full(fifo_full),
        .pix_valid(pix_valid), .pix_data(pix_data), .buf_idx(buf_idx)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: every presented pixel must match the head of the scoreboard (R4)
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (sb_q.size() == 0) begin
                check("R4 unexpected pixel", {22'd0, buf_idx, pix_data}, 32'h3ff);
            end else begin
                logic [9:0] e;
                e = sb_q.pop_front();
                check("R4 pixel data/buffer", {22'd0, buf_idx, pix_data}, {22'd0, e});
            end
        end
    end

    // one pixel clock period: inactive level, then the sampling edge
    task automatic px(input logic hs, input logic vs, input logic [7:0] d, input logic ff);
        @(negedge clk);
        sen_pclk  = cfg_pclk_fall;
        sen_hsync = hs ^ cfg_hsync_low;
        sen_vsync = vs ^ cfg_vsync_low;
        sen_data  = d;
        fifo_full = ff;
        @(negedge clk);
        sen_pclk = ~cfg_pclk_fall;
        if (pend_en) begin
            stat_clr      = 1'b1;
            stat_clr_data = pend_clr;
        end
        @(negedge clk);
        stat_clr = 1'b0;
        pend_en  = 1'b0;
    endtask

    task automatic vsync_pulse();
        px(1'b0, 1'b1, 8'h00, 1'b0);
        px(1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic send_line(input int nexp, input int base, input int ff_at);
        for (int p = 0; p < NPX; p++) begin
            logic ex;
            ex = !dropped && (p < nexp);
            if (ex) sb_q.push_back({exp_buf, 8'(base + p)});
            px(1'b1, 1'b0, 8'(base + p), p == ff_at);
            if (ex && p == ff_at) dropped = 1'b1;
        end
        px(1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic send_frame(input int lines, input int nexp, input int ff_line, input int ff_px);
        vsync_pulse();
        dropped = 1'b0;
        for (int l = 0; l < lines; l++) begin
            send_line(nexp, 16 * l + 32 * int'(exp_buf), (l == ff_line) ? ff_px : -1);
        end
    endtask

    task automatic write_mask(input logic [6:0] m);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic clear(input logic [6:0] c);
        @(negedge clk);
        stat_clr = 1'b1; stat_clr_data = c;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 raw", {25'd0, raw_status}, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        check("R1 buf", {30'd0, buf_idx}, 32'h0);
        check("R1 pix_valid", {31'd0, pix_valid}, 32'h0);

        // R2 disabled: whole frame ignored
        send_frame(VS, 0, -1, -1);
        check("R2 raw while disabled", {25'd0, raw_status}, 32'h0);
        check("R2 buf while disabled", {30'd0, buf_idx}, 32'h0);

        // R3/R4/R5 first frame, buffer 0, lines longer than width
        cfg_enable = 1'b1;
        write_mask(7'h7f);
        vsync_pulse();
        check("R3 SOF0", {25'd0, raw_status}, 32'h08);
        dropped = 1'b0;
        for (int l = 0; l < VS; l++) send_line(HS, 16 * l, -1);
        check("R5 EOF0", {25'd0, raw_status}, 32'h09);
        check("R5 buf advanced", {30'd0, buf_idx}, 32'h1);
        check("R4 scoreboard drained", sb_q.size(), 32'h0);
        check("R9 irq on", {31'd0, irq}, 32'h1);
        exp_buf = 2'd1;

        // R10 write-one-to-clear, per bit
        clear(7'h08);
        check("R10 clear bit3 only", {25'd0, raw_status}, 32'h01);
        clear(7'h01);
        check("R10 all cleared", {25'd0, raw_status}, 32'h00);

        // R6 three-buffer rotation
        send_frame(VS, HS, -1, -1);
        check("R6 buf after frame1", {30'd0, buf_idx}, 32'h2);
        exp_buf = 2'd2;
        send_frame(VS, HS, -1, -1);
        check("R6 wrap to 0", {30'd0, buf_idx}, 32'h0);
        check("R6 status bufs 1,2", {25'd0, raw_status}, 32'h36);
        exp_buf = 2'd0;
        clear(7'h7f);

        // R6 two-buffer rotation
        cfg_two_buf = 1'b1;
        send_frame(VS, HS, -1, -1);
        check("R6 two-buf step", {30'd0, buf_idx}, 32'h1);
        exp_buf = 2'd1;
        send_frame(VS, HS, -1, -1);
        check("R6 two-buf wrap", {30'd0, buf_idx}, 32'h0);
        check("R6 two-buf status", {25'd0, raw_status}, 32'h1b);
        exp_buf = 2'd0;
        cfg_two_buf = 1'b0;
        clear(7'h7f);

        // R7 early frame sync aborts
        vsync_pulse();
        dropped = 1'b0;
        send_line(HS, 0, -1);
        send_frame(VS, HS, -1, -1);
        check("R7 abort leaves one EOF", {25'd0, raw_status}, 32'h09);
        check("R7 buf after restart", {30'd0, buf_idx}, 32'h1);
        exp_buf = 2'd1;
        clear(7'h7f);

        // R8 overflow drops frame
        send_frame(VS, HS, 1, 1);
        check("R8 overflow status", {25'd0, raw_status}, 32'h50);
        check("R8 buf kept", {30'd0, buf_idx}, 32'h1);
        check("R8 scoreboard drained", sb_q.size(), 32'h0);
        clear(7'h7f);

        // R9 masking
        send_frame(VS, HS, -1, -1);
        write_mask(7'h40);
        check("R9 masked none", {25'd0, masked_status}, 32'h00);
        check("R9 irq off", {31'd0, irq}, 32'h0);
        write_mask(7'h02);
        check("R9 masked eof1", {25'd0, masked_status}, 32'h02);
        check("R9 irq back on", {31'd0, irq}, 32'h1);
        exp_buf = 2'd2;
        clear(7'h7f);

        // R10 event wins over same-cycle clear
        pend_en  = 1'b1;
        pend_clr = 7'h20;
        vsync_pulse();
        check("R10 set wins", {25'd0, raw_status}, 32'h20);
        dropped = 1'b0;
        for (int l = 0; l < VS; l++) send_line(HS, 16 * l, -1);
        check("R10 frame end", {25'd0, raw_status}, 32'h24);
        clear(7'h7f);

        // R11 inverted syncs and falling-edge sampling; R2 disable resets buffer
        @(negedge clk);
        cfg_enable = 1'b0;
        @(negedge clk);
        check("R2 disable resets buf", {30'd0, buf_idx}, 32'h0);
        cfg_hsync_low = 1'b1; cfg_vsync_low = 1'b1; cfg_pclk_fall = 1'b1;
        sen_hsync = 1'b1; sen_vsync = 1'b1; sen_pclk = 1'b1;
        @(negedge clk);
        cfg_enable = 1'b1;
        exp_buf = 2'd0;
        send_frame(VS, HS, -1, -1);
        check("R11 frame with inverted syncs", {25'd0, raw_status}, 32'h09);
        check("R11 buf advanced", {30'd0, buf_idx}, 32'h1);
        check("R11 scoreboard drained", sb_q.size(), 32'h0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule